// File: doc/BRIEF.md
# Masked Interrupt Flag Controller

This block gathers five single-cycle event pulses (two timers, a time-of-day alarm, a serial data event and an external flag input) into a sticky flag register. A separate enable mask decides which latched events may raise the shared interrupt request. The request output is active low and stays asserted until software reads the flag register.

Software reaches the block through one register location. A write changes the mask: the top bit of the written byte selects whether the ones in the low bits enable or disable the matching sources. A read returns the latched flags with a summary bit on top that shows whether a request is pending. In the same clock edge the read clears every flag and releases the request. Flags latch whether or not they are enabled, so software can also poll for them.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A pulse on src_pulse bit i latches flag bit i (0 timer A, 1 timer B, 2 alarm, 3 serial, 4 external) at the next clock edge, even if the mask bit is 0. The flag is visible in rd_data[4:0].
- R2: A write with wr_data[7]=1 sets every mask bit whose wr_data bit is 1.
- R3: A write with wr_data[7]=0 clears every mask bit whose wr_data bit is 1. Mask bits written as 0 keep their value.
- R4: When (flags & mask) is nonzero after a clock edge, irq_n is low from that edge and rd_data[7] reads 1.
- R5: A read (rd_en high) returns the current flags and summary bit. At that clock edge it clears all flags and the summary bit, and irq_n goes high.
- R6: A mask-set write that enables an already pending flag drives irq_n low at the edge of the write.
- R7: A source pulse in the same cycle as a read is discarded. It raises no request and leaves no flag.
- R8: rd_data[6:5] always read 0.
- R9: After reset all flags and mask bits are 0 and irq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 5 | One-cycle event pulses, one bit per source |
| wr_en | input | 1 | Mask write strobe |
| wr_data | input | 8 | Mask write data; bit 7 selects set (1) or clear (0) |
| rd_en | input | 1 | Flag read strobe; clears the flags at the clock edge |
| rd_data | output | 8 | {summary, 2'b00, flags[4:0]} |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Events are sent both with their mask bits off and with them on. This shows that latching does not depend on the mask, while the request does. Set-writes and clear-writes are applied to a mask that holds a mix of enabled and disabled bits, so the bench can confirm that only the written ones change. Enabling a source after its flag is already pending separates a request that is computed from the current state from one that only reacts to a new event. A read that coincides with a new pulse, once with no flags pending and once with another flag pending, shows that the pulse is dropped and that the clear acts on everything.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pulse,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            rd_en,
  output logic [7:0]      rd_data,
  output logic            irq_n
);
  localparam int PADW = 7 - NSRC;

  logic [NSRC-1:0] flags_q, flags_d;
  logic [NSRC-1:0] mask_q, mask_d;
  logic            pend_q, pend_d;

  assign flags_d = rd_en ? '0 : (flags_q | src_pulse);

  always_comb begin
    mask_d = mask_q;
    if (wr_en) begin
      if (wr_data[7]) mask_d = mask_q | wr_data[NSRC-1:0];
      else            mask_d = mask_q & ~wr_data[NSRC-1:0];
    end
  end

  assign pend_d = rd_en ? 1'b0 : (pend_q | (|(flags_d & mask_d)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      mask_q  <= mask_d;
      pend_q  <= pend_d;
    end
  end

  assign rd_data = {pend_q, {PADW{1'b0}}, flags_q};
  assign irq_n   = ~pend_q;

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data == 8'h00) && irq_n);

  a_r1_pulse_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && |src_pulse) |=> ((rd_data[NSRC-1:0] & $past(src_pulse)) == $past(src_pulse)));

  a_r2_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7]) |=> ((mask_q & $past(wr_data[NSRC-1:0])) == $past(wr_data[NSRC-1:0])));

  a_r3_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7]) |=> ((mask_q & $past(wr_data[NSRC-1:0])) == '0));

  a_r4_request_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && |(flags_q & mask_q)) |=> !irq_n);

  a_r4_request_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (|rd_data[NSRC-1:0]));

  a_r7_race_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && |src_pulse) |=> (rd_data[NSRC-1:0] == '0));

  a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:5] == 2'b00);
endmodule

// File: tb/test_irq_flag_ctrl.sv
module test_irq_flag_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [4:0] src_pulse = '0;
  logic       wr_en = 0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 0;
  logic [7:0] rd_data;
  logic       irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  irq_flag_ctrl i_irq_flag_ctrl (.clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [4:0] v);
    src_pulse = v; @(posedge clk); @(negedge clk); src_pulse = '0;
  endtask

  task automatic wmask(input logic [7:0] v);
    wr_en = 1; wr_data = v; @(posedge clk); @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic rdreg(output logic [7:0] v, input logic [4:0] racing = '0);
    rd_en = 1; src_pulse = racing; #1 v = rd_data;
    @(posedge clk); @(negedge clk); rd_en = 0; src_pulse = '0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R9 irq_n", {7'b0, irq_n}, 8'h01);
    rdreg(v); check("R9 flags", v, 8'h00);
    pulse(5'h1f); check("R9 mask zero", {7'b0, irq_n}, 8'h01);
    rdreg(v); check("R1 all flags latch masked", v, 8'h1f);
  endtask

  task automatic t_poll;
    logic [7:0] v;
    pulse(5'h15); check("R1 masked no irq", {7'b0, irq_n}, 8'h01);
    rdreg(v); check("R1 R8 poll value", v, 8'h15);
    rdreg(v); check("R5 cleared", v, 8'h00);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wmask(8'h83); check("R2 no pending", {7'b0, irq_n}, 8'h01);
    pulse(5'h02); check("R4 irq low", {7'b0, irq_n}, 8'h00);
    rdreg(v); check("R4 summary bit", v, 8'h82);
    check("R5 irq released", {7'b0, irq_n}, 8'h01);
    pulse(5'h01); rdreg(v); check("R2 bit0 enabled", v, 8'h81);
  endtask

  task automatic t_clear;
    logic [7:0] v;
    wmask(8'h01);
    pulse(5'h01); check("R3 bit0 disabled", {7'b0, irq_n}, 8'h01);
    rdreg(v); check("R3 flag only", v, 8'h01);
    pulse(5'h02); check("R3 bit1 kept", {7'b0, irq_n}, 8'h00);
    rdreg(v); check("R3 bit1 read", v, 8'h82);
  endtask

  task automatic t_late_enable;
    logic [7:0] v;
    pulse(5'h10); check("R6 pending masked", {7'b0, irq_n}, 8'h01);
    wmask(8'h90); check("R6 irq on enable", {7'b0, irq_n}, 8'h00);
    rdreg(v); check("R6 read", v, 8'h90);
  endtask

  task automatic t_race;
    logic [7:0] v;
    rdreg(v, 5'h02); check("R7 read value", v, 8'h00);
    check("R7 no irq", {7'b0, irq_n}, 8'h01);
    rdreg(v); check("R7 flag dropped", v, 8'h00);
    pulse(5'h08);
    rdreg(v, 5'h10); check("R7 pending returned", v, 8'h08);
    check("R7 irq stays high", {7'b0, irq_n}, 8'h01);
    rdreg(v); check("R7 R5 all cleared", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_poll();
    t_mask();
    t_clear();
    t_late_enable();
    t_race();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule